// File: doc/BRIEF.md
# Immediate-Compare Compact Branch Resolver

This block decides the outcome of one 32-bit compact branch that compares a source register with a 7-bit immediate, or that tests one bit of that register. It takes the instruction word, the address of the instruction, the value read for the source register and a flag for 64-bit operation. One clock later it returns four results: whether the branch is taken, the target address, the fall-through address, and the next PC. Compact branches have no delay slot, so the next PC is simply the target or the fall-through address.

A reserved-instruction flag is raised when a bit-test branch names a bit that does not exist in 32-bit operation. Source register 0 always reads as zero. Because of this, the same encoding turns into an unconditional branch or a no-op, depending on the condition. A caller presents an instruction with a one-cycle `valid_i` strobe. The results appear with a matching `valid_o` strobe on the next cycle and stay unchanged until the next strobe.

Top module: `brt_resolver`

## Requirements
- R1: While `rst_ni` is low, every output is zero.
- R2: When `valid_i` is high at a clock edge, the results for that instruction appear after that edge and `valid_o` is high for exactly that one cycle. `valid_o` is low after any edge where `valid_i` was low, and all other outputs then keep their values.
- R3: Instruction fields:
  - The selector is `instr_i[20:18]`, the immediate is `instr_i[17:11]` (unsigned) and the source register index is `instr_i[25:21]`.
  - The 12-bit byte offset has bit 11 equal to `instr_i[0]`, bits 10..1 equal to `instr_i[10:1]`, and bit 0 equal to zero. It is sign-extended.
  - `fall_o` = PC+4 and `target_o` = PC+4+offset, both modulo 2^XLEN.
- R4: `next_pc_o` equals `target_o` when `taken_o` is 1, and equals `fall_o` otherwise.
- R5: Selector 0 is taken when the register equals the zero-extended immediate. Selector 4 is taken when they differ.
- R6: Selectors 2 and 6 compare the register with the immediate as signed values: 2 is taken on greater-or-equal, 6 on less-than. Selectors 3 and 7 do the same as unsigned values: 3 on greater-or-equal, 7 on less-than.
- R7: Selector 1 is taken when bit number `imm` of the register is 0, and selector 5 when that bit is 1. A bit number of XLEN or more reads as 0.
- R8: When `mode64_i` is 0 and a bit-test selector (1 or 5) has `imm` ≥ 32:
  - `exc_o` is 1, `taken_o` is 0 and `next_pc_o` is `fall_o`.
  - No compare selector ever sets `exc_o`.
- R9: Register index 0 reads as zero whatever `rs_val_i` holds. As a result:
  - Index 0 with imm 0 is unconditional for selectors 0, 2 and 3.
  - Index 0 is unconditional for selector 1 and for selector 4 with a nonzero imm.
  - Index 0 is never taken for selector 5, for selector 4 with imm 0, or for selector 0 with a nonzero imm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction strobe |
| instr_i | input | 32 | Instruction word |
| pc_i | input | XLEN | Address of the instruction |
| rs_val_i | input | XLEN | Value read for the source register |
| mode64_i | input | 1 | 1 selects 64-bit operation |
| valid_o | output | 1 | Result strobe |
| taken_o | output | 1 | Branch taken |
| exc_o | output | 1 | Reserved-instruction exception |
| target_o | output | XLEN | PC+4+offset |
| fall_o | output | XLEN | PC+4 |
| next_pc_o | output | XLEN | Address to fetch next |

## Verification
The only state in this block is the stage of output registers. A wrong capture enable or a stale register therefore shows up on the very next `valid_o` strobe: the reported addresses or the taken flag belong to an earlier instruction. It can also show up on the cycle after a strobe as outputs that change while `valid_i` was low. Decode faults, such as a misplaced offset bit, a wrong signedness or a missing register-0 mask, change `taken_o`, `target_o` or `exc_o` for that same strobe. So every fault becomes visible one cycle after the instruction that triggers it.

// File: rtl/brt_pkg.sv
package brt_pkg;
  typedef enum logic [2:0] {
    SEL_EQ  = 3'd0,
    SEL_BZ  = 3'd1,
    SEL_GE  = 3'd2,
    SEL_GEU = 3'd3,
    SEL_NE  = 3'd4,
    SEL_BNZ = 3'd5,
    SEL_LT  = 3'd6,
    SEL_LTU = 3'd7
  } sel_e;

  localparam int IMM_W = 7;
  localparam int OFF_W = 12;
  localparam int IDX_W = 5;

  typedef struct packed {
    sel_e             sel;
    logic [IDX_W-1:0] idx;
    logic [IMM_W-1:0] imm;
    logic [OFF_W-1:0] off;
  } fields_t;

  function automatic fields_t split_instr(input logic [31:0] w);
    fields_t f;
    f.sel = sel_e'(w[20:18]);
    f.idx = w[25:21];
    f.imm = w[17:11];
    f.off = {w[0], w[10:1], 1'b0};
    return f;
  endfunction

  function automatic logic is_bit_test(input sel_e s);
    return (s == SEL_BZ) || (s == SEL_BNZ);
  endfunction
endpackage

// File: rtl/brt_target.sv
module brt_target #(
  parameter int XLEN  = 64,
  parameter int OFF_W = 12
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [XLEN-1:0]  fall_o,
  output logic [XLEN-1:0]  target_o
);
  localparam int EXT_W = XLEN - OFF_W;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] off_sx;

  assign off_sx   = {{EXT_W{off_i[OFF_W-1]}}, off_i};
  assign fall_o   = pc_i + STEP;
  assign target_o = fall_o + off_sx;
endmodule

// File: rtl/brt_cond.sv
module brt_cond
  import brt_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int IMM_W    = 7,
  parameter int NARROW_W = 32
) (
  input  sel_e             sel_i,
  input  logic [XLEN-1:0]  opnd_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             mode64_i,
  output logic             take_o,
  output logic             exc_o
);
  localparam int BIX_W = $clog2(XLEN);

  logic [XLEN-1:0] imm_zx;
  logic            sel_bit;
  logic            eq, lts, ltu;
  logic            bix_over;

  assign imm_zx = {{(XLEN-IMM_W){1'b0}}, imm_i};
  assign eq     = (opnd_i == imm_zx);
  assign lts    = ($signed(opnd_i) < $signed(imm_zx));
  assign ltu    = (opnd_i < imm_zx);

  // index beyond register width reads as zero
  generate
    if (IMM_W > BIX_W) begin : g_wide_imm
      assign bix_over = |imm_i[IMM_W-1:BIX_W];
      assign sel_bit  = bix_over ? 1'b0 : opnd_i[imm_i[BIX_W-1:0]];
    end else begin : g_narrow_imm
      assign bix_over = 1'b0;
      assign sel_bit  = opnd_i[imm_i];
    end
  endgenerate

  logic narrow_bad;
  assign narrow_bad = !mode64_i && (imm_i >= IMM_W'(NARROW_W));

  always_comb begin
    take_o = 1'b0;
    exc_o  = 1'b0;
    unique case (sel_i)
      SEL_EQ:  take_o = eq;
      SEL_NE:  take_o = !eq;
      SEL_GE:  take_o = !lts;
      SEL_LT:  take_o = lts;
      SEL_GEU: take_o = !ltu;
      SEL_LTU: take_o = ltu;
      SEL_BZ, SEL_BNZ: begin
        if (narrow_bad) begin
          exc_o = 1'b1;
        end else begin
          take_o = (sel_i == SEL_BZ) ? !sel_bit : sel_bit;
        end
      end
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/brt_resolver.sv
module brt_resolver
  import brt_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int NARROW_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic            mode64_i,
  output logic            valid_o,
  output logic            taken_o,
  output logic            exc_o,
  output logic [XLEN-1:0] target_o,
  output logic [XLEN-1:0] fall_o,
  output logic [XLEN-1:0] next_pc_o
);
  fields_t         f;
  logic [XLEN-1:0] opnd;
  logic [XLEN-1:0] fall_d, target_d;
  logic            take_d, exc_d;
  logic            unused_hi;

  assign f         = split_instr(instr_i);
  assign unused_hi = ^{instr_i[31:26]};
  // register 0 reads as zero
  assign opnd      = (f.idx == '0) ? '0 : rs_val_i;

  brt_target #(.XLEN(XLEN), .OFF_W(OFF_W)) u_tgt (
    .pc_i     (pc_i),
    .off_i    (f.off),
    .fall_o   (fall_d),
    .target_o (target_d)
  );

  brt_cond #(.XLEN(XLEN), .IMM_W(IMM_W), .NARROW_W(NARROW_W)) u_cond (
    .sel_i    (f.sel),
    .opnd_i   (opnd),
    .imm_i    (f.imm),
    .mode64_i (mode64_i),
    .take_o   (take_d),
    .exc_o    (exc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      taken_o   <= 1'b0;
      exc_o     <= 1'b0;
      target_o  <= '0;
      fall_o    <= '0;
      next_pc_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        taken_o   <= take_d;
        exc_o     <= exc_d;
        target_o  <= target_d;
        fall_o    <= fall_d;
        next_pc_o <= take_d ? target_d : fall_d;
      end
    end
  end
endmodule

// File: rtl/brt_chk.sv
module brt_chk #(
  parameter int XLEN     = 64,
  parameter int NARROW_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [31:0]     instr_i,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] rs_val_i,
  input logic            mode64_i,
  input logic            valid_o,
  input logic            taken_o,
  input logic            exc_o,
  input logic [XLEN-1:0] target_o,
  input logic [XLEN-1:0] fall_o,
  input logic [XLEN-1:0] next_pc_o
);
  logic unused_chk;
  assign unused_chk = ^{rs_val_i, instr_i[31:26], instr_i[10:0]};

  logic bt_narrow_bad;
  assign bt_narrow_bad = (instr_i[20:18] == 3'd1 || instr_i[20:18] == 3'd5)
                         && !mode64_i && (instr_i[17:11] >= 7'(NARROW_W));

  p_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(taken_o) && $stable(target_o) && $stable(exc_o));
  p_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> fall_o == $past(pc_i) + XLEN'(4));
  p_next_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> next_pc_o == (taken_o ? target_o : fall_o));
  p_ri_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && bt_narrow_bad |=> exc_o && !taken_o);
  p_noexc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !bt_narrow_bad |=> !exc_o);
  p_zero_bz_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode64_i && instr_i[25:21] == 5'd0 && instr_i[20:18] == 3'd1 |=> taken_o);
endmodule

bind brt_resolver brt_chk #(.XLEN(XLEN), .NARROW_W(NARROW_W)) u_chk (.*);

// File: tb/sim_brt_resolver.sv
`timescale 1ns/1ps
module sim_brt_resolver;
  localparam int XL = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [31:0]   instr = '0;
  logic [XL-1:0] pc = '0;
  logic [XL-1:0] rsv = '0;
  logic          m64 = 1'b0;
  logic          valid_o, taken_o, exc_o;
  logic [XL-1:0] target_o, fall_o, next_o;

  int vectors = 0;
  int errs = 0;
  bit done = 0;

  logic          e_valid = 0, e_taken = 0, e_exc = 0;
  logic [XL-1:0] e_target = '0, e_fall = '0, e_next = '0;
  string         e_tag = "R1";

  always #5 clk = ~clk;

  brt_resolver #(.XLEN(XL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr),
    .pc_i(pc), .rs_val_i(rsv), .mode64_i(m64),
    .valid_o(valid_o), .taken_o(taken_o), .exc_o(exc_o),
    .target_o(target_o), .fall_o(fall_o), .next_pc_o(next_o)
  );

  function automatic logic [31:0] mk(int sel, int idx, int imm, int off, logic [5:0] hi);
    logic [31:0] w;
    logic [11:0] o;
    o = 12'(off);
    w = '0;
    w[31:26] = hi;
    w[25:21] = 5'(idx);
    w[20:18] = 3'(sel);
    w[17:11] = 7'(imm);
    w[10:1]  = o[10:1];
    w[0]     = o[11];
    return w;
  endfunction

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid = 0; e_taken = 0; e_exc = 0;
      e_target = '0; e_fall = '0; e_next = '0;
    end else begin
      e_valid = valid;
      if (valid) begin
        int sel, idx, imm;
        longint off;
        logic [XL-1:0] v;
        logic b;
        sel = int'(instr[20:18]);
        idx = int'(instr[25:21]);
        imm = int'(instr[17:11]);
        off = longint'(instr[10:1]) * 2 - (instr[0] ? 2048 : 0);
        v = (idx == 0) ? '0 : rsv;
        e_exc = 0;
        e_taken = 0;
        case (sel)
          0: begin e_taken = (v == XL'(imm)); e_tag = "R5"; end
          4: begin e_taken = (v != XL'(imm)); e_tag = "R5"; end
          2: begin e_taken = ($signed(v) >= longint'(imm)); e_tag = "R6"; end
          6: begin e_taken = ($signed(v) < longint'(imm)); e_tag = "R6"; end
          3: begin e_taken = (v >= XL'(imm)); e_tag = "R6"; end
          7: begin e_taken = (v < XL'(imm)); e_tag = "R6"; end
          default: begin
            e_tag = "R7";
            if (!m64 && imm >= 32) begin
              e_exc = 1; e_tag = "R8";
            end else begin
              b = (imm >= XL) ? 1'b0 : v[imm];
              e_taken = (sel == 1) ? (b == 1'b0) : (b == 1'b1);
            end
          end
        endcase
        if (idx == 0 && e_tag != "R8") e_tag = "R9";
        e_fall   = pc + 64'd4;
        e_target = pc + 64'd4 + 64'(off);
        e_next   = e_taken ? e_target : e_fall;
      end
    end
  end

  task automatic cmp(string tag, logic [XL-1:0] act, logic [XL-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        cmp("R1 valid_o", XL'(valid_o), '0);
        cmp("R1 taken_o", XL'(taken_o), '0);
        cmp("R1 next_pc_o", next_o, '0);
      end else begin
        cmp("R2 valid_o", XL'(valid_o), XL'(e_valid));
        cmp("R3 fall_o", fall_o, e_fall);
        cmp("R3 target_o", target_o, e_target);
        cmp("R4 next_pc_o", next_o, e_next);
        cmp("R8 exc_o", XL'(exc_o), XL'(e_exc));
        cmp({e_tag, " taken_o"}, XL'(taken_o), XL'(e_taken));
      end
    end
  end

  task automatic put(logic [31:0] w, logic [XL-1:0] p, logic [XL-1:0] r, logic m);
    @(posedge clk); #2;
    valid = 1; instr = w; pc = p; rsv = r; m64 = m;
    @(posedge clk); #2;
    valid = 0;
    instr = ~w; pc = ~p; rsv = ~r; // must not disturb held outputs (R2)
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R5 / R9 equal and not-equal with register 0
    put(mk(0, 0, 0, 100, 6'h3f), 64'h1000, 64'hdead, 1);
    put(mk(0, 0, 5, 100, 0), 64'h1000, 64'h5, 1);
    put(mk(0, 3, 5, -64, 0), 64'h2000, 64'h5, 1);
    put(mk(0, 3, 5, -64, 0), 64'h2000, 64'h6, 1);
    put(mk(4, 0, 0, 8, 0), 64'h3000, 64'h1, 1);
    put(mk(4, 0, 9, 8, 0), 64'h3000, 64'h9, 1);
    put(mk(4, 7, 9, 8, 0), 64'h3000, 64'h9, 0);
    // R6 signed and unsigned
    put(mk(2, 4, 10, 2046, 0), 64'h4000, -64'sd3, 1);
    put(mk(6, 4, 10, -2048, 0), 64'h4000, -64'sd3, 1);
    put(mk(3, 4, 10, 20, 0), 64'h4000, -64'sd3, 1);
    put(mk(7, 4, 10, 20, 0), 64'h4000, -64'sd3, 1);
    put(mk(2, 0, 0, 20, 0), 64'h4000, -64'sd3, 1);
    put(mk(3, 0, 0, 20, 0), 64'h4000, 64'h0, 1);
    put(mk(7, 0, 1, 20, 0), 64'h4000, 64'h77, 1);
    // R7 bit tests
    put(mk(1, 2, 3, 40, 0), 64'h5000, 64'h8, 1);
    put(mk(5, 2, 3, 40, 0), 64'h5000, 64'h8, 1);
    put(mk(5, 2, 63, 40, 0), 64'h5000, 64'h8000_0000_0000_0000, 1);
    put(mk(5, 2, 100, 40, 0), 64'h5000, '1, 1);
    put(mk(1, 2, 100, 40, 0), 64'h5000, '1, 1);
    put(mk(5, 2, 40, 40, 0), 64'h5000, '1, 1);
    // R8 reserved bit index in 32-bit mode
    put(mk(5, 2, 40, 40, 0), 64'h5000, '1, 0);
    put(mk(1, 0, 32, 40, 0), 64'h5000, '0, 0);
    put(mk(1, 0, 31, 40, 0), 64'h5000, '0, 0);
    put(mk(5, 0, 31, 40, 0), 64'h5000, '1, 0);
    // R3 address wrap
    put(mk(0, 0, 0, -4, 0), 64'hffff_ffff_ffff_fffc, '0, 1);
    // mixed patterns, back-to-back
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #2;
      valid = ($urandom % 4) != 0;
      instr = $urandom;
      if (($urandom % 3) == 0) instr[17:11] = 7'($urandom % 4);
      pc = {$urandom, $urandom};
      rsv = (($urandom % 4) == 0) ? XL'(instr[17:11]) : {$urandom, $urandom};
      m64 = $urandom;
    end
    @(posedge clk); #2 valid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      errs++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule